// File: doc/BRIEF.md
# Serial Register Front End for a Precision DAC

This block is the digital receive side of a serially programmed digital-to-analog converter. A host shifts 24-bit words in on a serial clock while a framing strobe is held low. When the strobe rises, the word is decoded. Its top byte is a command and its low 16 bits are a payload. The command can write the converter code, write the control word, request a register readback, or reset every register.

The latched code is presented as a parallel word to the analog core, which lies outside this block. A clear input forces that word to zero without losing the stored code. A read-only status word records malformed frames and drives an active-low fault flag.

The serial output has three uses:
- It carries the selected register during the frame that follows a readback request.
- In chained mode it passes along the bits that fall off the far end of the shift register.
- Otherwise it stays low.

All serial inputs are treated as asynchronous and are oversampled by the system clock.

Top module: `dacsr_top`

## Requirements
- R1: While the framing strobe is low, each rising serial clock shifts the data bit into a 24-bit register MSB first. On the strobe's rising edge the word is decoded: bits 23..16 are the command and bits 15..0 are the payload. Serial clock edges while the strobe is high are not counted.
- R2: Command 0x01 stores payload bits 15 down to 16-CODE_W as the converter code, which appears on `dac_code`. The payload bits below them are ignored and read back as zero.
- R3: Command 0x02 stores the 16-bit payload as the control word. Bit 0 drives `dac_en` and bit 1 enables chained mode.
- R4: Command 0x03 requests a readback. Payload bits 1..0 select the register: 0 is status, 1 is code, 2 is control and 3 is zero. During the next frame `sdo` shows the word {8'h00, value} MSB first, with each bit valid before the rising serial clock that shifts it.
- R5: Command 0x00 addresses the read-only status slot. It, and any command not listed in these requirements, changes no register.
- R6: A frame whose count of rising serial clock edges is not exactly 24 is discarded. It sets status bit 0, which stays set until a reset.
- R7: `fault_n` is low exactly when the status word is nonzero.
- R8: Command 0x55 clears the code, control and status registers, the same as reset.
- R9: While `clear` is high `dac_code` is zero. When `clear` falls the stored code returns, and `clear` never alters the stored code.
- R10: In chained mode, during a frame `sdo` presents the word shifted in by the previous frame, MSB first.
- R11: With chained mode off and no readback pending, `sdo` is low.
- R12: A synchronous active-low reset zeroes all registers. After reset `dac_code` is 0, `dac_en` is 0, `fault_n` is 1 and `sdo` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial shift clock, asynchronous |
| sdin | input | 1 | Serial data in |
| latch | input | 1 | Framing strobe; low while shifting, rising edge commits the frame |
| clear | input | 1 | Forces the parallel code to zero while high |
| sdo | output | 1 | Serial data out for readback or chaining |
| dac_code | output | CODE_W | Parallel converter code |
| dac_en | output | 1 | Output enable taken from the control word |
| fault_n | output | 1 | Active-low fault flag |

## Verification
Code writes sweep 34 payloads whose upper and lower bit groups vary independently. Each is checked both on `dac_code` and through readback, which separates a mis-sliced code field from a lost low nibble. Frame lengths from 20 to 28 edges separate the single accepted length from its neighbours on either side, and each bad frame is followed by a status readback and a reset command. Writes to the status slot and to an unknown command are compared against the previously stored values. A chained frame is compared bit by bit against the word sent one frame earlier, which shows whether the serial output comes from the shift register or from the readback path.

// File: rtl/dacsr_pkg.sv
// Package dacsr_pkg
// Shared frame geometry, command codes and control bit positions for the
// DAC serial register front end. Assumes a fixed 24-bit frame made of an
// 8-bit command and a 16-bit payload.
package dacsr_pkg;
    localparam int FRAME_W = 24;
    localparam int CMD_W   = 8;
    localparam int PAY_W   = FRAME_W - CMD_W;
    localparam int CNT_W   = $clog2(FRAME_W + 2);

    localparam logic [CMD_W-1:0] CMD_STATUS = 8'h00;
    localparam logic [CMD_W-1:0] CMD_DATA   = 8'h01;
    localparam logic [CMD_W-1:0] CMD_CTRL   = 8'h02;
    localparam logic [CMD_W-1:0] CMD_READ   = 8'h03;
    localparam logic [CMD_W-1:0] CMD_SWRST  = 8'h55;

    localparam int CTRL_OUTEN = 0;
    localparam int CTRL_CHAIN = 1;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_DATA   = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_NONE   = 2'd3
    } rsel_e;
endpackage

// File: rtl/dacsr_sync.sv
// Module dacsr_sync
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes STAGES >= 2. The reset value is a parameter so that idle-high
// inputs do not create a false edge when reset is released.
module dacsr_sync #(
    parameter int          STAGES  = 2,
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int CHAIN_W = STAGES * W;

    logic [CHAIN_W-1:0] chain;

    // Shift the input bundle through the register chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[CHAIN_W-W-1:0], d};
    end

    assign q = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/dacsr_frame_rx.sv
// Module dacsr_frame_rx
// Serial frame receiver. Detects edges on the synchronized serial clock and
// strobe, shifts data MSB first while the strobe is low and counts the edges.
// On a readback request the shift register is loaded with the reply word, so
// the same register serves both incoming data and the outgoing bit stream.
// Assumes each serial clock phase lasts several system clocks.
module dacsr_frame_rx
    import dacsr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_s,
    input  logic               sdin_s,
    input  logic               latch_s,
    input  logic               rb_load,
    input  logic [FRAME_W-1:0] rb_word,
    input  logic               sdo_drive,
    output logic [FRAME_W-1:0] word,
    output logic               latch_rise,
    output logic               frame_good,
    output logic               sdo
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_GOOD = CNT_W'(FRAME_W);

    logic             sclk_p;
    logic             latch_p;
    logic [CNT_W-1:0] bit_cnt;
    logic             shift_en;

    // Hold the previous samples for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_p  <= 1'b0;
            latch_p <= 1'b1;
        end else begin
            sclk_p  <= sclk_s;
            latch_p <= latch_s;
        end
    end

    assign latch_rise = latch_s & ~latch_p;
    assign shift_en   = sclk_s & ~sclk_p & ~latch_s;

    // Shift register: either load the reply word or take in one serial bit.
    always_ff @(posedge clk) begin
        if (!rst_n)        word <= '0;
        else if (rb_load)  word <= rb_word;
        else if (shift_en) word <= {word[FRAME_W-2:0], sdin_s};
    end

    // Count the edges of the current frame, saturating at the counter limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                            bit_cnt <= '0;
        else if (latch_rise)                   bit_cnt <= '0;
        else if (shift_en && bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
    end

    assign frame_good = (bit_cnt == CNT_GOOD);
    assign sdo        = sdo_drive & word[FRAME_W-1];
endmodule

// File: rtl/dacsr_regs.sv
// Module dacsr_regs
// Command decoder and register file. On each strobe rise it either records a
// frame error or acts on the command byte: code write, control write,
// readback request or register reset. Also builds the readback reply.
// Assumes word is stable in the cycle latch_rise is high.
module dacsr_regs
    import dacsr_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               latch_rise,
    input  logic               frame_good,
    input  logic [FRAME_W-1:0] word,
    output logic [CODE_W-1:0]  data_q,
    output logic [PAY_W-1:0]   ctrl_q,
    output logic               ferr_q,
    output logic               rd_pending,
    output logic               rb_load,
    output logic [FRAME_W-1:0] rb_word
);
    localparam int PAD_W = PAY_W - CODE_W;

    logic [CMD_W-1:0] cmd;
    logic [PAY_W-1:0] pay;
    logic [PAY_W-1:0] rb_val;
    rsel_e            sel;

    assign cmd = word[FRAME_W-1 -: CMD_W];
    assign pay = word[PAY_W-1:0];
    assign sel = rsel_e'(pay[1:0]);

    // Select the register value that a readback request returns.
    always_comb begin
        case (sel)
            SEL_STATUS: rb_val = PAY_W'(ferr_q);
            SEL_DATA:   rb_val = PAY_W'(data_q) << PAD_W;
            SEL_CTRL:   rb_val = ctrl_q;
            default:    rb_val = '0;
        endcase
    end

    // Decode a committed frame and update the registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q     <= '0;
            ctrl_q     <= '0;
            ferr_q     <= 1'b0;
            rd_pending <= 1'b0;
            rb_load    <= 1'b0;
            rb_word    <= '0;
        end else begin
            rb_load <= 1'b0;
            if (latch_rise) begin
                rd_pending <= 1'b0;
                if (!frame_good) begin
                    ferr_q <= 1'b1;
                end else begin
                    case (cmd)
                        CMD_DATA: data_q <= pay[PAY_W-1 -: CODE_W];
                        CMD_CTRL: ctrl_q <= pay;
                        CMD_READ: begin
                            rd_pending <= 1'b1;
                            rb_load    <= 1'b1;
                            rb_word    <= {{CMD_W{1'b0}}, rb_val};
                        end
                        CMD_SWRST: begin
                            data_q <= '0;
                            ctrl_q <= '0;
                            ferr_q <= 1'b0;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/dacsr_top.sv
// Module dacsr_top
// Top of the DAC serial register front end. Synchronizes the serial pins,
// receives frames, decodes commands and drives the parallel code, the enable,
// the fault flag and the serial output. Assumes the serial clock runs well
// below the system clock (each phase at least four system clocks).
module dacsr_top
    import dacsr_pkg::*;
#(
    parameter int CODE_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sdin,
    input  logic              latch,
    input  logic              clear,
    output logic              sdo,
    output logic [CODE_W-1:0] dac_code,
    output logic              dac_en,
    output logic              fault_n
);
    logic               sclk_s, sdin_s, latch_s, clear_s;
    logic [FRAME_W-1:0] word;
    logic [FRAME_W-1:0] rb_word;
    logic               latch_rise, frame_good, rb_load;
    logic [CODE_W-1:0]  data_q;
    logic [PAY_W-1:0]   ctrl_q;
    logic               ferr_q, rd_pending;
    logic               sdo_drive;

    dacsr_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b000)) sync_lo_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({clear, sdin, sclk}),
        .q     ({clear_s, sdin_s, sclk_s})
    );

    dacsr_sync #(.STAGES(SYNC_STAGES), .W(1), .RST_VAL(1'b1)) sync_hi_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (latch),
        .q     (latch_s)
    );

    assign sdo_drive = ctrl_q[CTRL_CHAIN] | rd_pending;

    dacsr_frame_rx rx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (sclk_s),
        .sdin_s     (sdin_s),
        .latch_s    (latch_s),
        .rb_load    (rb_load),
        .rb_word    (rb_word),
        .sdo_drive  (sdo_drive),
        .word       (word),
        .latch_rise (latch_rise),
        .frame_good (frame_good),
        .sdo        (sdo)
    );

    dacsr_regs #(.CODE_W(CODE_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .latch_rise (latch_rise),
        .frame_good (frame_good),
        .word       (word),
        .data_q     (data_q),
        .ctrl_q     (ctrl_q),
        .ferr_q     (ferr_q),
        .rd_pending (rd_pending),
        .rb_load    (rb_load),
        .rb_word    (rb_word)
    );

    // Register the parallel code, forcing zero while clear is held.
    always_ff @(posedge clk) begin
        if (!rst_n)       dac_code <= '0;
        else if (clear_s) dac_code <= '0;
        else              dac_code <= data_q;
    end

    assign dac_en  = ctrl_q[CTRL_OUTEN];
    assign fault_n = ~ferr_q;
endmodule

// File: rtl/dacsr_chk.sv
// Module dacsr_chk
// Property checker bound to dacsr_top. It observes the frame commit strobe,
// the command word and the register state, and checks the ports over time.
module dacsr_chk
    import dacsr_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               latch_rise,
    input logic               frame_good,
    input logic [FRAME_W-1:0] word,
    input logic               clear_s,
    input logic [CODE_W-1:0]  data_q,
    input logic [PAY_W-1:0]   ctrl_q,
    input logic               rd_pending,
    input logic               sdo,
    input logic [CODE_W-1:0]  dac_code,
    input logic               fault_n
);
    logic [CMD_W-1:0] cmd;
    assign cmd = word[FRAME_W-1 -: CMD_W];

    assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_s |=> (dac_code == '0));

    assert_bad_frame_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_rise && !frame_good) |=> ($stable(data_q) && $stable(ctrl_q)));

    assert_bad_frame_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_rise && !frame_good) |=> !fault_n);

    assert_status_slot_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_rise && frame_good && cmd == CMD_STATUS) |=> ($stable(data_q) && $stable(ctrl_q)));

    assert_swrst_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_rise && frame_good && cmd == CMD_SWRST) |=> (data_q == '0 && ctrl_q == '0 && fault_n));

    assert_sdo_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[CTRL_CHAIN] && !rd_pending) |-> !sdo);
endmodule

bind dacsr_top dacsr_chk #(.CODE_W(CODE_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .latch_rise (latch_rise),
    .frame_good (frame_good),
    .word       (word),
    .clear_s    (clear_s),
    .data_q     (data_q),
    .ctrl_q     (ctrl_q),
    .rd_pending (rd_pending),
    .sdo        (sdo),
    .dac_code   (dac_code),
    .fault_n    (fault_n)
);

// File: tb/dacsr_top_tb.sv
// Bench dacsr_top_tb_top
// Drives serial frames into dacsr_top and compares the ports with values
// worked out from the requirements.
module dacsr_top_tb_top;
    localparam int CODE_W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdin = 1'b0, latch = 1'b1, clear = 1'b0;
    logic sdo, dac_en, fault_n;
    logic [CODE_W-1:0] dac_code;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dacsr_top #(.CODE_W(CODE_W), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdin(sdin), .latch(latch),
        .clear(clear), .sdo(sdo), .dac_code(dac_code), .dac_en(dac_en),
        .fault_n(fault_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One frame with nbits serial clock edges; returns sdo seen before each edge.
    task automatic frame(input logic [23:0] w, input int nbits, output logic [23:0] got);
        got = '0;
        latch = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdin = (i < 24) ? w[23 - i] : 1'b0;
            repeat (6) @(negedge clk);
            if (i < 24) got[23 - i] = sdo;
            sclk = 1'b1;
            repeat (6) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (4) @(negedge clk);
        latch = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic send(input logic [23:0] w);
        logic [23:0] g;
        frame(w, 24, g);
    endtask

    // Readback request followed by a no-op frame that captures the reply.
    task automatic readback(input logic [1:0] sel, output logic [23:0] got);
        send({8'h03, 14'b0, sel});
        frame(24'h000000, 24, got);
    endtask

    initial begin
        logic [23:0] got;
        logic [15:0] pay;
        logic [11:0] last_code;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R12: state after reset
        chk("R12 code", 32'(dac_code), 32'h0);
        chk("R12 en", 32'(dac_en), 32'h0);
        chk("R12 fault_n", 32'(fault_n), 32'h1);
        chk("R12 sdo", 32'(sdo), 32'h0);

        // R1 R2 R4: sweep of code writes, checked on the port and by readback
        for (int i = 0; i < 34; i++) begin
            pay = (i == 32) ? 16'hFFFF : (i == 33) ? 16'h000F : 16'(i * 2113 + i);
            send({8'h01, pay});
            chk("R2 code port", 32'(dac_code), 32'(pay[15:4]));
            readback(2'd1, got);
            chk("R4 code readback", 32'(got), {8'h0, 8'h00, pay[15:4], 4'h0});
        end
        last_code = 12'hFFF;
        send({8'h01, 16'hABC7});
        last_code = 12'hABC;

        // R11: sdo low after a plain write frame
        frame({8'h00, 16'h0000}, 24, got);
        chk("R11 sdo quiet", 32'(got), 32'h0);

        // R3: control write drives the enable; readback of control
        send({8'h02, 16'h1235});
        chk("R3 en set", 32'(dac_en), 32'h1);
        readback(2'd2, got);
        chk("R4 ctrl readback", 32'(got), 32'h001235);
        send({8'h02, 16'h0000});
        chk("R3 en clear", 32'(dac_en), 32'h0);
        readback(2'd3, got);
        chk("R4 sel3 zero", 32'(got), 32'h0);

        // R5: status slot and unknown command change nothing
        send({8'h00, 16'hFFFF});
        send({8'h04, 16'hFFFF});
        chk("R5 code kept", 32'(dac_code), 32'(last_code));
        chk("R5 fault_n", 32'(fault_n), 32'h1);
        readback(2'd0, got);
        chk("R5 status zero", 32'(got), 32'h0);
        readback(2'd2, got);
        chk("R5 ctrl kept", 32'(got), 32'h0);

        // R6 R7 R8: frame length sweep, each bad length discarded then reset
        for (int n = 20; n <= 28; n++) begin
            frame({8'h01, 16'h5550}, n, got);
            if (n == 24) begin
                chk("R6 good length", 32'(dac_code), 32'h555);
                chk("R7 no fault", 32'(fault_n), 32'h1);
                send({8'h01, 16'hABC0});
            end else begin
                chk("R6 bad length code", 32'(dac_code), 32'hABC);
                chk("R7 fault low", 32'(fault_n), 32'h0);
                readback(2'd0, got);
                chk("R6 status bit0", 32'(got), 32'h000001);
                chk("R7 still low", 32'(fault_n), 32'h0);
                send({8'h02, 16'h0001});
                send({8'h55, 16'h1234});
                chk("R8 code cleared", 32'(dac_code), 32'h0);
                chk("R8 en cleared", 32'(dac_en), 32'h0);
                chk("R8 fault cleared", 32'(fault_n), 32'h1);
                send({8'h01, 16'hABC0});
            end
        end

        // R1: serial clock edges while strobe is high are not counted
        for (int i = 0; i < 3; i++) begin
            sclk = 1'b1; repeat (6) @(negedge clk);
            sclk = 1'b0; repeat (6) @(negedge clk);
        end
        send({8'h01, 16'h7E10});
        chk("R1 edges outside frame ignored", 32'(dac_code), 32'h7E1);
        chk("R1 no fault", 32'(fault_n), 32'h1);

        // R9: clear forces zero and the code returns afterwards
        clear = 1'b1;
        repeat (8) @(negedge clk);
        chk("R9 cleared", 32'(dac_code), 32'h0);
        send({8'h01, 16'h3C40});
        chk("R9 write under clear", 32'(dac_code), 32'h0);
        clear = 1'b0;
        repeat (8) @(negedge clk);
        chk("R9 restored", 32'(dac_code), 32'h3C4);

        // R10: chained mode passes the previous word out bit by bit
        send({8'h02, 16'h0002});
        send(24'h00C3A5);
        frame(24'h005A3C, 24, got);
        chk("R10 chain out", 32'(got), 32'h00C3A5);
        frame(24'h000000, 24, got);
        chk("R10 chain second", 32'(got), 32'h005A3C);
        send({8'h02, 16'h0000});
        frame(24'h000000, 24, got);
        chk("R11 quiet after chain off", 32'(got), 32'h0);

        // R12: synchronous reset mid run
        send({8'h02, 16'h0001});
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R12 reset code", 32'(dac_code), 32'h0);
        chk("R12 reset en", 32'(dac_en), 32'h0);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 190000; c++) begin
            @(negedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule